// File: doc/BRIEF.md
# Stacked DMA Interrupt Status Register

This block holds the interrupt status of a DMA engine. A read clears it. Each interrupt source delivers one-cycle event pulses. The first event on a source sets that source's visible status bit. If a later event arrives while the bit is still visible, it is not lost: it is held in a one-deep stack kept for each source. A read returns the visible bits and clears every one of them. The stack is then held back for a fixed settling period. At the end of that period the stacked events are loaded into the visible bits, so software that reads again after the settling time sees the events that were waiting.

Events that arrive in the cycle of a read, or during the settling period, also go to the stack. The top bit of the register is a live FIFO-empty level. It is never cleared and never raises an interrupt. An 8-bit enable mask decides which visible bits drive the interrupt output. A separate pending flag reports any visible interrupt bit, with or without the mask, to a higher-level status register.

Top module: `dma_irq_stack`

## Requirements
- R1: Read data bit positions are: 7 FIFO empty, 6 parity error, 5 bus fault, 4 abort, 3 single step, 2 script interrupt, 1 reserved (always 0), 0 illegal instruction. The event input uses the same positions. Events on bits 7 and 1 have no effect.
- R2: An event on a source whose visible bit is clear, outside a settling period and not in a read cycle, sets that bit at the next clock edge.
- R3: A cycle with `rd_i` high shows the current bits on `rdata_o`. At that edge every visible interrupt bit is cleared.
- R4: An event on a source whose bit is already visible is held in that source's stack. Any number of such events merge into one stacked copy.
- R5: A read starts a settling period of SETTLE cycles (default 8, below the 12-cycle read spacing). At the SETTLE-th edge after the read edge, the stacked bits join the visible bits and the stack empties.
- R6: An event in a read cycle, or during the settling period, is never lost. It goes to the stack and appears when the stack reloads.
- R7: `rdata_o[7]` follows `fifo_empty_i` combinationally. A read does not clear it, and it never drives `irq_o` or `dma_pend_o`.
- R8: `irq_o` is high when any visible interrupt bit has its mask bit set. The mask is loaded from `mask_wdata_i` when `mask_wr_i` is high. Masked sources still set their status bit.
- R9: `dma_pend_o` is high when any interrupt bit is visible, regardless of the mask. It is low in the cycle after a read.
- R10: After reset all visible, stacked and mask bits are zero, and `rdata_o` equals `fifo_empty_i` in bit 7 with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle interrupt event pulses, one per bit position |
| fifo_empty_i | input | 1 | DMA FIFO empty level |
| rd_i | input | 1 | Register read strobe; clears on the edge |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write data |
| rdata_o | output | 8 | Status read data |
| irq_o | output | 1 | Masked interrupt request |
| dma_pend_o | output | 1 | Unmasked pending summary |

## Verification
The bench targets the edges where events can be dropped. These are an event in the same cycle as a read, events during the settling window, and a repeated event on a bit that is already visible. A design that clears on read without masking against the new event would lose the event. A design without merging would reload more than once. An off-by-one timer would make stacked bits reappear one cycle early or late, and the per-clock comparison with the reference model catches that. The bench also pulses the reserved and FIFO-empty bit positions and flips the mask while bits are visible. It checks that masked sources still show status and that the FIFO-empty level survives reads.

// File: rtl/irqstk_pkg.sv
package irqstk_pkg;

  localparam int STAT_W = 8;

  localparam int POS_FIFO_EMPTY = 7;
  localparam int POS_PARITY     = 6;
  localparam int POS_BUS_FAULT  = 5;
  localparam int POS_ABORT      = 4;
  localparam int POS_STEP       = 3;
  localparam int POS_SCRIPT     = 2;
  localparam int POS_RESERVED   = 1;
  localparam int POS_ILLEGAL    = 0;

  // positions that carry a stackable interrupt
  function automatic logic [STAT_W-1:0] int_bits();
    logic [STAT_W-1:0] m;
    m = '0;
    m[POS_PARITY]    = 1'b1;
    m[POS_BUS_FAULT] = 1'b1;
    m[POS_ABORT]     = 1'b1;
    m[POS_STEP]      = 1'b1;
    m[POS_SCRIPT]    = 1'b1;
    m[POS_ILLEGAL]   = 1'b1;
    return m;
  endfunction

  // software view: interrupt bits plus live FIFO level, reserved forced low
  function automatic logic [STAT_W-1:0] read_view(input logic [STAT_W-1:0] vis,
                                                  input logic fifo_empty);
    logic [STAT_W-1:0] v;
    v = vis & int_bits();
    v[POS_FIFO_EMPTY] = fifo_empty;
    return v;
  endfunction

endpackage

// File: rtl/irqstk_settle_timer.sv
module irqstk_settle_timer #(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  output logic hold_o,
  output logic reload_o
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] START = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (rd_i)           cnt_q <= START;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o   = (cnt_q > CW'(1));
  assign reload_o = (cnt_q == CW'(1)) && !rd_i;

  // R5
  settle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (cnt_q == START));

  // R5
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && !rd_i |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irqstk_cell.sv
module irqstk_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic evt_i,
  input  logic hold_i,
  input  logic reload_i,
  output logic vis_o,
  output logic stk_o
);
  logic vis_q, stk_q;
  logic base_vis, base_stk;
  logic evt_direct;   // event lands in the visible bit
  logic evt_stacked;  // event lands in the stack
  logic open_w;

  assign open_w      = !rd_i && !hold_i;
  assign base_vis    = rd_i ? 1'b0 : (vis_q | (reload_i & stk_q));
  assign base_stk    = reload_i ? 1'b0 : stk_q;
  assign evt_direct  = evt_i && open_w && !base_vis;
  assign evt_stacked = evt_i && !evt_direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= 1'b0;
      stk_q <= 1'b0;
    end else begin
      vis_q <= base_vis | evt_direct;
      stk_q <= base_stk | evt_stacked;
    end
  end

  assign vis_o = vis_q;
  assign stk_o = stk_q;

  // R3
  cell_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !vis_q);

  // R6
  cell_evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (vis_q || stk_q));

  // R4
  cell_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_q && evt_i && !rd_i) |=> (vis_q && stk_q));

  // R5
  cell_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && stk_q) |=> vis_q);

endmodule

// File: rtl/irqstk_summary.sv
module irqstk_summary
  import irqstk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic [STAT_W-1:0] vis_i,
  output logic              irq_o,
  output logic              pend_o
);
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] live_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  assign live_int = vis_i & int_bits();
  assign irq_o    = |(live_int & mask_q);
  assign pend_o   = |live_int;

  // R8
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && (mask_wdata_i == '0)) |=> !irq_o);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_o);

endmodule

// File: rtl/dma_irq_stack.sv
module dma_irq_stack
  import irqstk_pkg::*;
#(
  parameter int SETTLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_i,
  input  logic       fifo_empty_i,
  input  logic       rd_i,
  input  logic       mask_wr_i,
  input  logic [7:0] mask_wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       dma_pend_o
);
  localparam logic [STAT_W-1:0] INT_M = int_bits();

  logic hold_w, reload_w;
  logic [STAT_W-1:0] vis_w, stk_w;
  logic unused_evt;

  assign unused_evt = ^(evt_i & ~INT_M) ^ ^stk_w;

  irqstk_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_i),
    .hold_o   (hold_w),
    .reload_o (reload_w)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (INT_M[b]) begin : g_int
      irqstk_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .evt_i    (evt_i[b]),
        .hold_i   (hold_w),
        .reload_i (reload_w),
        .vis_o    (vis_w[b]),
        .stk_o    (stk_w[b])
      );
    end else begin : g_none
      assign vis_w[b] = 1'b0;
      assign stk_w[b] = 1'b0;
    end
  end

  irqstk_summary u_sum (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .vis_i        (vis_w),
    .irq_o        (irq_o),
    .pend_o       (dma_pend_o)
  );

  assign rdata_o = read_view(vis_w, fifo_empty_i);

  // R3
  top_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((rdata_o & INT_M) == '0));

  // R9
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !dma_pend_o);

  // R1
  reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_o[POS_RESERVED]);

  // R7
  fifo_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[POS_FIFO_EMPTY] == fifo_empty_i));

endmodule

// File: tb/dma_irq_stack_test.sv
`timescale 1ns/1ps
module dma_irq_stack_test;
  localparam int SETTLE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt;
  logic       fifo;
  logic       rd;
  logic       mwr;
  logic [7:0] mdat;
  logic [7:0] rdata;
  logic       irq, pend;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dma_irq_stack #(.SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .fifo_empty_i(fifo), .rd_i(rd),
    .mask_wr_i(mwr), .mask_wdata_i(mdat), .rdata_o(rdata), .irq_o(irq),
    .dma_pend_o(pend)
  );

  // behavioural reference model
  logic [7:0] m_vis, m_stk, m_mask;
  int m_cnt;

  always @(posedge clk) begin : model
    logic [7:0] nv, ns;
    if (!rst_n) begin
      m_vis = 0; m_stk = 0; m_mask = 0; m_cnt = 0;
    end else begin
      nv = m_vis; ns = m_stk;
      for (int i = 0; i < 8; i++) begin
        if (i == 7 || i == 1) continue;
        if (rd) begin
          nv[i] = 1'b0;
          if (evt[i]) ns[i] = 1'b1;
        end else if (m_cnt > 1) begin
          if (evt[i]) ns[i] = 1'b1;
        end else begin
          if (m_cnt == 1) begin
            nv[i] = m_vis[i] | m_stk[i];
            ns[i] = 1'b0;
          end
          if (evt[i]) begin
            if (nv[i]) ns[i] = 1'b1;
            else       nv[i] = 1'b1;
          end
        end
      end
      if (rd)             m_cnt = SETTLE;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (mwr) m_mask = mdat;
      m_vis = nv; m_stk = ns;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [7:0] ex;
      ex = m_vis & 8'h7D;
      ex[7] = fifo;
      chk(rdata === ex, "R1/R3/R5 rdata", rdata, ex);
      chk(irq === |(m_vis & m_mask & 8'h7D), "R8 irq", irq, |(m_vis & m_mask & 8'h7D));
      chk(pend === |(m_vis & 8'h7D), "R9 pend", pend, |(m_vis & 8'h7D));
    end
  end

  task automatic cyc(input logic [7:0] e, input logic r);
    evt = e; rd = r;
    @(posedge clk); #1;
    evt = 0; rd = 0;
  endtask

  task automatic setmask(input logic [7:0] d);
    mwr = 1; mdat = d;
    @(posedge clk); #1;
    mwr = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(8'h00, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt = 0; fifo = 1; rd = 0; mwr = 0; mdat = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    chk(rdata == 8'h80, "R10 reset rdata", rdata, 8'h80);
    chk(!irq && !pend, "R10 reset outputs", {irq, pend}, 0);

    setmask(8'hFF);
    // R2 direct set
    cyc(8'h04, 0);
    chk(rdata == 8'h84, "R2 set", rdata, 8'h84);
    chk(irq && pend, "R8/R9 asserted", {irq, pend}, 3);
    // R4 two more events merge into one stacked copy
    cyc(8'h04, 0);
    cyc(8'h04, 0);
    chk(rdata == 8'h84, "R3 read view", rdata, 8'h84);
    cyc(8'h00, 1);
    chk(rdata == 8'h80, "R3 cleared", rdata, 8'h80);
    chk(!pend, "R9 pend cleared", pend, 0);
    idle(SETTLE - 1);
    chk(rdata == 8'h80, "R5 still settling", rdata, 8'h80);
    idle(1);
    chk(rdata == 8'h84, "R5 reload", rdata, 8'h84);
    cyc(8'h00, 1);
    idle(12);
    chk(rdata == 8'h80, "R4 single copy", rdata, 8'h80);

    // R6 event in read cycle and during hold-off
    cyc(8'h40, 1);
    chk(rdata == 8'h80, "R6 read-cycle event hidden", rdata, 8'h80);
    idle(2);
    cyc(8'h01, 0);
    idle(SETTLE - 4);
    chk(rdata == 8'h80, "R6 hold-off event hidden", rdata, 8'h80);
    idle(1);
    chk(rdata == 8'hC1, "R6 reappear", rdata, 8'hC1);
    cyc(8'h00, 1);
    idle(12);

    // R1 events on FIFO and reserved positions do nothing
    cyc(8'h82, 0);
    chk(rdata == 8'h80, "R1 ignored positions", rdata, 8'h80);
    chk(!pend && !irq, "R1 no pending", {irq, pend}, 0);

    // R7 live FIFO level
    fifo = 0; #1;
    chk(rdata == 8'h00, "R7 fifo low", rdata, 8'h00);
    fifo = 1; #1;
    cyc(8'h00, 1);
    chk(rdata == 8'h80, "R7 survives read", rdata, 8'h80);
    chk(!irq && !pend, "R7 no interrupt", {irq, pend}, 0);
    idle(12);

    // R8 masking
    setmask(8'h00);
    cyc(8'h10, 0);
    chk(rdata == 8'h90, "R8 masked status set", rdata, 8'h90);
    chk(!irq, "R8 masked irq", irq, 0);
    chk(pend, "R9 pend ignores mask", pend, 1);
    setmask(8'h10);
    chk(irq, "R8 unmasked irq", irq, 1);
    setmask(8'hEF);
    chk(!irq, "R8 remasked irq", irq, 0);
    cyc(8'h00, 1);
    idle(12);

    // random traffic, reads spaced at least 12 cycles
    begin
      int gap = 0;
      for (int n = 0; n < 3000; n++) begin
        evt  = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
        fifo = (($urandom % 8) != 0);
        rd   = (gap >= 12) && (($urandom % 4) == 0);
        mwr  = (($urandom % 40) == 0);
        mdat = 8'($urandom);
        gap  = rd ? 0 : gap + 1;
        @(posedge clk); #1;
      end
      evt = 0; rd = 0; mwr = 0;
      idle(2);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule